// File: doc/BRIEF.md
# Scan-Chain Identification Code Probe

This block is a host-side sequencer that tests whether a guessed assignment of pins to the four JTAG roles is correct. A single-cycle pulse on `start` begins a probe. The block then generates a test clock at a fixed division of the system clock. It drives the mode-select and data-in lines so that the target is forced into Test-Logic-Reset and then walked along the data-register path into Shift-DR. No instruction scan is performed, because the probe depends on the identification register being the instruction selected after reset.

In Shift-DR the block clocks exactly 32 bits while it captures the target's data-out line. It then returns the target to Run-Test/Idle and presents the captured word together with a plausibility flag. A flag that stays low marks the pin guess as wrong. A controller outside the block chooses the next assignment and pulses `start` again. Choosing pins is not part of this block.

Top module: `scanid_probe`

## Requirements
- R1: After reset, `tck` is 0, `tms` is 1, `tdi` is 0, `busy`, `done` and `id_ok` are 0, and `id_word` is all zeros.
- R2: A `start` pulse seen while idle raises `busy` on the next clock. While busy, `tck` is a square wave with a period of 2*HALF_DIV system clocks, beginning low. Its first rising edge comes HALF_DIV clocks after `start` was taken. When idle, `tck` stays low.
- R3: The first five test-clock cycles of a probe present `tms` = 1, so a target in any state reaches Test-Logic-Reset.
- R4: The next four cycles present `tms` = 0, 1, 0, 0 (Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR). No instruction-register path is entered.
- R5: Then 32 shift cycles follow. `tms` is 0 on the first 31 of them and 1 on the 32nd. `tdi` is 1 during all 32 shift cycles and 0 on every other cycle and while idle.
- R6: After the shift cycles, two cycles present `tms` = 1 and then 0 (Update-DR, then Run-Test/Idle), which gives 43 test-clock cycles in all. On the clock where the last falling edge of `tck` is produced, `done` pulses for one cycle and `busy` falls. The target is left in Run-Test/Idle.
- R7: `tms` and `tdi` change only together with a falling edge of `tck`, or when a probe is accepted. `tdo` is sampled on the system clock where `tck` rises, during the 32 shift cycles only.
- R8: `id_word` bit k holds the `tdo` value sampled on shift cycle k+1, so the first bit seen lands in bit 0. `id_word` changes only on the clock that raises `done` and is held until the next probe completes.
- R9: `id_ok` is 1 only if all of the following hold: bit 0 of the word is 1, the word is neither all zeros nor all ones, and bits 11:1 are not all ones. It is updated together with `id_word`.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The probe in progress keeps its timing and completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a probe |
| tdo | input | 1 | Serial data returned by the target |
| tck | output | 1 | Generated test clock |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Serial data to the target |
| busy | output | 1 | High from the clock after an accepted start until done |
| done | output | 1 | One-cycle pulse when a probe finishes |
| id_word | output | ID_W | Captured identification word, first bit in bit 0 |
| id_ok | output | 1 | Captured word passed the plausibility test |

## Verification
The bench attaches a behavioural target state machine. In the first probe the target starts in Pause-DR, so a reset sequence that is one cycle short would leave it outside Run-Test/Idle, and a stray instruction-path step would deliver the wrong word. The bench applies stuck-low and stuck-high data lines, a word with bit 0 clear, and a word whose manufacturer field is all ones. A plausibility test with a missing term would raise `id_ok` on one of these. A second `start` is issued in the middle of a probe, and a design that restarts on it would shift its whole `tck` and `tms` timeline against the reference. Comparison on every clock also catches a `tms` change on a rising edge, a wrong shift count, a bit-order reversal, and an `id_word` that changes between completions.

// File: rtl/scanid_pkg.sv
package scanid_pkg;

    // Per test-clock-cycle pin controls for one step of a probe
    typedef struct packed {
        logic tms;
        logic tdi;
        logic sample;
    } step_ctl_t;

    // Cycles between reset and the first shift: Idle, Select-DR, Capture-DR, into Shift-DR
    localparam int PREAMBLE_TCKS = 4;
    // Cycles after the shift: Update-DR, Run-Test/Idle
    localparam int TAIL_TCKS     = 2;
    // Manufacturer field position inside the identification word
    localparam int MFR_LSB       = 1;
    localparam int MFR_MSB       = 11;

    localparam step_ctl_t IDLE_CTL = '{tms: 1'b1, tdi: 1'b0, sample: 1'b0};

    function automatic int total_tcks(int reset_tcks, int id_w);
        return reset_tcks + PREAMBLE_TCKS + id_w + TAIL_TCKS;
    endfunction

    // Controls presented during test-clock cycle s of a probe
    function automatic step_ctl_t step_ctl(int s, int reset_tcks, int id_w);
        step_ctl_t c;
        int sh_first;
        int sh_last;
        sh_first = reset_tcks + PREAMBLE_TCKS;
        sh_last  = sh_first + id_w - 1;
        c = '{tms: 1'b0, tdi: 1'b0, sample: 1'b0};
        if (s < reset_tcks) begin
            c.tms = 1'b1;
        end else if (s < sh_first) begin
            c.tms = (s == reset_tcks + 1);
        end else if (s <= sh_last) begin
            c.tms    = (s == sh_last);
            c.tdi    = 1'b1;
            c.sample = 1'b1;
        end else begin
            c.tms = (s == sh_last + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/scanid_tick.sv
module scanid_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV == 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == TOP) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == TOP);
        end
    endgenerate
endmodule

// File: rtl/scanid_seq.sv
module scanid_seq
    import scanid_pkg::*;
#(
    parameter int RESET_TCKS = 5,
    parameter int ID_W       = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic tck,
    output logic tms,
    output logic tdi,
    output logic busy,
    output logic done,
    output logic sample,
    output logic finish
);
    localparam int TOTAL = total_tcks(RESET_TCKS, ID_W);
    localparam int SW    = $clog2(TOTAL + 1);
    localparam logic [SW-1:0] LAST = SW'(TOTAL - 1);

    logic [SW-1:0] step;
    step_ctl_t     ctl_q;

    assign sample = busy && tick && !tck && ctl_q.sample;
    assign finish = busy && tick && tck && (step == LAST);
    assign tms    = ctl_q.tms;
    assign tdi    = ctl_q.tdi;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            tck   <= 1'b0;
            step  <= '0;
            ctl_q <= IDLE_CTL;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    step  <= '0;
                    ctl_q <= step_ctl(0, RESET_TCKS, ID_W);
                end
            end else if (tick) begin
                if (!tck) begin
                    tck <= 1'b1;
                end else begin
                    tck <= 1'b0;
                    if (step == LAST) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        ctl_q <= IDLE_CTL;
                    end else begin
                        step  <= step + 1'b1;
                        ctl_q <= step_ctl(int'(step) + 1, RESET_TCKS, ID_W);
                    end
                end
            end
        end
    end

    // R7: pins are steady across every rising test-clock edge
    p_pins_steady_at_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> ($stable(tms) && $stable(tdi)));

    // R2: no test clock activity outside a probe
    p_tck_low_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    // R6: done comes only as busy ends
    p_done_closes_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R10: a probe cannot be cut short, whatever start does
    p_busy_persists_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));
endmodule

// File: rtl/scanid_capture.sv
module scanid_capture
    import scanid_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample,
    input  logic            finish,
    input  logic            tdo,
    output logic [ID_W-1:0] id_word,
    output logic            id_ok
);
    logic [ID_W-1:0] shreg;
    logic            plausible;

    always_comb begin
        plausible = shreg[0]
                    && (|shreg)
                    && !(&shreg)
                    && !(&shreg[MFR_MSB:MFR_LSB]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            id_word <= '0;
            id_ok   <= 1'b0;
        end else begin
            if (sample) begin
                shreg <= {tdo, shreg[ID_W-1:1]};
            end
            if (finish) begin
                id_word <= shreg;
                id_ok   <= plausible;
            end
        end
    end

    // R9: a flagged word always has its marker bit and a real manufacturer field
    p_ok_implies_fields_r9: assert property (@(posedge clk) disable iff (rst)
        id_ok |-> (id_word[0] && !(&id_word[MFR_MSB:MFR_LSB])));

    // R8: the reported word only moves when a probe completes
    p_word_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !finish |=> ($stable(id_word) && $stable(id_ok)));
endmodule

// File: rtl/scanid_probe.sv
module scanid_probe
    import scanid_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int RESET_TCKS = 5,
    parameter int ID_W       = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            tdo,
    output logic            tck,
    output logic            tms,
    output logic            tdi,
    output logic            busy,
    output logic            done,
    output logic [ID_W-1:0] id_word,
    output logic            id_ok
);
    logic tick;
    logic sample;
    logic finish;

    scanid_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    scanid_seq #(.RESET_TCKS(RESET_TCKS), .ID_W(ID_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tick   (tick),
        .tck    (tck),
        .tms    (tms),
        .tdi    (tdi),
        .busy   (busy),
        .done   (done),
        .sample (sample),
        .finish (finish)
    );

    scanid_capture #(.ID_W(ID_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample),
        .finish  (finish),
        .tdo     (tdo),
        .id_word (id_word),
        .id_ok   (id_ok)
    );

    // R5: data-in is only driven high inside a probe
    p_tdi_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tdi);
endmodule

// File: tb/scanid_probe_bench.sv
module scanid_probe_bench;
    localparam int H     = 3;
    localparam int RT    = 5;
    localparam int IDW   = 32;
    localparam int TCKS  = RT + 4 + IDW + 2;
    localparam int SH0   = RT + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tdo;
    logic tck, tms, tdi, busy, done, id_ok;
    logic [IDW-1:0] id_word;

    always #5 clk = ~clk;

    scanid_probe #(.HALF_DIV(H), .RESET_TCKS(RT), .ID_W(IDW)) u_scanid_probe (
        .clk(clk), .rst(rst), .start(start), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
        .id_word(id_word), .id_ok(id_ok)
    );

    // ---------------- behavioural target ----------------
    typedef enum logic [3:0] {
        TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
        SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR
    } tap_t;

    tap_t        ts = PDR;
    logic [31:0] tsr = '0;
    logic [31:0] tap_id = '0;
    logic        tdo_b = 1'b0;
    int          tdo_mode = 0;   // 0 target, 1 stuck low, 2 stuck high

    function automatic tap_t tap_next(tap_t s, logic m);
        case (s)
            TLR:  return m ? TLR  : RTI;
            RTI:  return m ? SDR  : RTI;
            SDR:  return m ? SIR  : CDR;
            CDR:  return m ? E1DR : SHDR;
            SHDR: return m ? E1DR : SHDR;
            E1DR: return m ? UDR  : PDR;
            PDR:  return m ? E2DR : PDR;
            E2DR: return m ? UDR  : SHDR;
            UDR:  return m ? SDR  : RTI;
            SIR:  return m ? TLR  : CIR;
            CIR:  return m ? E1IR : SHIR;
            SHIR: return m ? E1IR : SHIR;
            E1IR: return m ? UIR  : PIR;
            PIR:  return m ? E2IR : PIR;
            E2IR: return m ? UIR  : SHIR;
            default: return m ? SDR : RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (ts == CDR)       tsr <= tap_id;
        else if (ts == SHDR) tsr <= {tdi, tsr[31:1]};
        ts <= tap_next(ts, tms);
    end

    always @(negedge tck) tdo_b <= (ts == SHDR) ? tsr[0] : 1'b0;

    assign tdo = (tdo_mode == 1) ? 1'b0 : (tdo_mode == 2) ? 1'b1 : tdo_b;

    // ---------------- reference model ----------------
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_n    = 0;
    logic [31:0] m_word = '0;
    bit          m_ok   = 0;
    logic [31:0] probe_word = '0;
    bit          stray  = 0;

    function automatic bit looks_valid(logic [31:0] w);
        if (w[0] == 1'b0)            return 0;
        if (w == 32'h0)              return 0;
        if (w == 32'hFFFF_FFFF)      return 0;
        if (w[11:1] == 11'h7FF)      return 0;
        return 1;
    endfunction

    function automatic bit exp_tms_at(int c);
        if (c < RT)            return 1;
        if (c == RT)           return 0;
        if (c == RT + 1)       return 1;
        if (c < SH0)           return 0;
        if (c < SH0 + IDW)     return (c == SH0 + IDW - 1);
        if (c == SH0 + IDW)    return 1;
        return 0;
    endfunction

    function automatic string tms_tag(int c);
        if (c < RT)        return "R3";
        if (c < SH0)       return "R4";
        if (c < SH0 + IDW) return "R5";
        return "R6";
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_n = 0; m_word = '0; m_ok = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1;
                    m_n    = 0;
                end
            end else begin
                m_n++;
                if (m_n == 2 * TCKS * H) begin
                    m_busy = 0;
                    m_done = 1;
                    m_word = probe_word;
                    m_ok   = looks_valid(probe_word);
                end
            end
        end
    end

    bit compare_on = 0;

    always @(negedge clk) begin
        if (compare_on) begin
            int  h;
            int  c;
            bit  e_tck, e_tms, e_tdi;
            h = m_n / H;
            c = h / 2;
            e_tck = m_busy ? bit'(h % 2) : 1'b0;
            e_tms = m_busy ? exp_tms_at(c) : 1'b1;
            e_tdi = m_busy && (c >= SH0) && (c < SH0 + IDW);
            check(tck === e_tck, "R2", "tck", 32'(tck), 32'(e_tck));
            check(tms === e_tms, m_busy ? tms_tag(c) : "R1", "tms", 32'(tms), 32'(e_tms));
            check(tdi === e_tdi, "R5", "tdi", 32'(tdi), 32'(e_tdi));
            check(busy === m_busy, stray ? "R10" : "R2", "busy", 32'(busy), 32'(m_busy));
            check(done === m_done, stray ? "R10" : "R6", "done", 32'(done), 32'(m_done));
            check(id_word === m_word, "R8", "id_word", id_word, m_word);
            check(id_ok === m_ok, "R9", "id_ok", 32'(id_ok), 32'(m_ok));
            if (m_done) begin
                check(id_word === probe_word, "R7", "sampled word", id_word, probe_word);
                check(ts == RTI, "R6", "target final state", 32'(ts), 32'(RTI));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_probe(logic [31:0] id, int mode, bit with_stray);
        tap_id   = id;
        tdo_mode = mode;
        probe_word = (mode == 1) ? 32'h0 : (mode == 2) ? 32'hFFFF_FFFF : id;
        stray = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (with_stray) begin
            repeat (100) @(negedge clk);
            stray = 1;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        repeat (2 * TCKS * H + 6) @(negedge clk);
    endtask

    bit all_done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(tck === 1'b0 && tms === 1'b1 && tdi === 1'b0, "R1", "pins after reset",
              {29'b0, tck, tms, tdi}, 32'h2);
        check(busy === 1'b0 && done === 1'b0 && id_ok === 1'b0, "R1", "flags after reset",
              {29'b0, busy, done, id_ok}, 32'h0);
        check(id_word === '0, "R1", "word after reset", id_word, 32'h0);
        compare_on = 1;

        run_probe(32'h1BA0_0477, 0, 0);  // target starts in Pause-DR: R3 reset works
        run_probe(32'h0, 2, 0);          // stuck high
        run_probe(32'h0, 1, 0);          // stuck low
        run_probe(32'h1234_5678, 0, 0);  // bit 0 clear
        run_probe(32'h0000_0FFF, 0, 1);  // manufacturer all ones, stray start R10
        run_probe(32'h8000_0001, 0, 1);  // valid, stray start
        run_probe(32'hFFFF_FFFE, 0, 0);  // bit 0 clear, near all ones
        run_probe(32'h4BA0_0A77, 0, 0);  // valid

        compare_on = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        all_done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule